// File: doc/BRIEF.md
# Host-to-coprocessor command mailbox

This block is the register-mapped meeting point between a host CPU and a secure coprocessor. The host loads sixteen 32-bit argument words and then writes a command word. That command write is the trigger. The command, together with a snapshot of the argument words, goes into a four-deep FIFO. The coprocessor sees the oldest entry on its own port and removes it with a one-cycle pop.

When the coprocessor finishes a command it pulses a done strobe and supplies a return value and sixteen result words. The block latches these for the host to read and records a completion event. Two separate queue events are also recorded: an attempted enqueue into a full queue, and an enqueue that fills the queue. These three events sit in a write-one-to-clear status register. A mask register gates them onto a single level interrupt. The host can also poll the queue occupancy and a coprocessor-ready flag.

All register offsets are word aligned. Any write with the two low address bits not both zero is ignored.

Top module: `cmdmbx_top`

## Requirements
- R1: Argument word k (k = 0..15) is written and read back at byte offset 4*k. All argument words reset to 0.
- R2: Each write to offset 0x40 pushes one entry while the queue holds fewer than 4 entries. The entry holds the written command and a snapshot of all argument words at that moment; later argument writes leave queued entries unchanged. The coprocessor port shows the oldest entry, with `cp_valid` high while the count is non-zero. A `cp_pop` pulse removes the oldest entry, so entries leave in the order they were pushed. Offset 0x40 reads as 0.
- R3: The register at offset 0xC4 reads with the queue count in bits 2:0, the `cp_ready` input in bit 8, and 0 in every other bit.
- R4: A write to 0x40 while the count is 4 is dropped. The count and the head entry are unchanged, and interrupt status bit 17 is set.
- R5: Interrupt status bit 18 is set when an accepted push without a simultaneous pop brings the count to 4.
- R6: A `cp_done` pulse latches `cp_retval`, readable at 0x80, and result word i, readable at 0x84 + 4*i. On the same clock edge it sets interrupt status bit 0.
- R7: The interrupt status register at offset 0xC8 holds bits 0, 17 and 18; all other bits read as 0. Writing 1 to a bit clears it, and writing 0 leaves it. A set event in the same cycle as a clear leaves the bit set.
- R8: The interrupt mask register at offset 0xCC holds bits 0, 17 and 18 and resets to 0x00060001. A mask bit of 1 suppresses the matching cause. `irq` is high while any status bit is set and its mask bit is 0.
- R9: After reset the count is 0, `cp_valid` is 0, the interrupt status is 0, `irq` is 0 and the latched results are 0.
- R10: A pop while the queue is empty has no effect. A push and a pop in the same cycle leave the count unchanged and advance the head.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 8 | Register byte address |
| bus_we | input | 1 | Register write enable |
| bus_wdata | input | 32 | Register write data |
| bus_rdata | output | 32 | Register read data for `bus_addr` (combinational) |
| irq | output | 1 | Level interrupt to the host |
| cp_ready | input | 1 | Coprocessor-ready flag, shown in bit 8 at offset 0xC4 |
| cp_valid | output | 1 | Queue holds at least one entry |
| cp_cmd | output | 32 | Command word of the oldest entry |
| cp_params | output | 512 | Argument snapshot of the oldest entry; word k in bits 32k+31:32k |
| cp_pop | input | 1 | One-cycle pulse that removes the oldest entry |
| cp_done | input | 1 | One-cycle pulse that posts results |
| cp_retval | input | 32 | Return value latched on `cp_done` |
| cp_status | input | 512 | Result words latched on `cp_done`; word i in bits 32i+31:32i |

## Verification
A wrong read or write pointer shows on `cp_cmd` and `cp_params` on the first edge after the push or pop that exposes it. The bench therefore checks the head after every pop and checks a per-entry snapshot value that differs between neighbouring entries. A wrong count shows at offset 0xC4 and in the full and overflow status bits on the next edge, because the drop decision and the fill event both depend on it. Status and mask faults appear on `irq` and at offset 0xC8 on the edge after the event or the register write. A lost result latch shows at offset 0x80 on the next edge.

// File: rtl/cmdmbx_pkg.sv
package cmdmbx_pkg;
    parameter int unsigned WORD_W  = 32;
    parameter int unsigned N_WORDS = 16;
    localparam int unsigned BLOCK_W = WORD_W * N_WORDS;

    typedef logic [WORD_W-1:0]  word_t;
    typedef logic [BLOCK_W-1:0] block_t;

    typedef struct packed {
        word_t  cmd;
        block_t prm;
    } entry_t;

    // word indices (byte offset / 4)
    localparam int unsigned WIX_CMD   = 16;
    localparam int unsigned WIX_RET   = 32;
    localparam int unsigned WIX_RES0  = 33;
    localparam int unsigned WIX_QSTAT = 49;
    localparam int unsigned WIX_ISTAT = 50;
    localparam int unsigned WIX_IMASK = 51;

    // bit positions
    localparam int unsigned BIT_DONE = 0;
    localparam int unsigned BIT_OVF  = 17;
    localparam int unsigned BIT_FULL = 18;
    localparam int unsigned BIT_RDY  = 8;
    localparam int unsigned CNT_FLD  = 3;
endpackage

// File: rtl/cmdmbx_queue.sv
module cmdmbx_queue
    import cmdmbx_pkg::*;
#(
    parameter int unsigned DEPTH = 4
) (
    input  logic   clk,
    input  logic   rst_n,
    input  logic   push,
    input  entry_t push_entry,
    input  logic   pop,
    output entry_t head,
    output logic   valid,
    output logic [CNT_FLD-1:0] count,
    output logic   drop,
    output logic   hit_full
);
    localparam int unsigned PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int unsigned CNT_W = $clog2(DEPTH + 1);

    typedef struct packed {
        entry_t [DEPTH-1:0] mem;
        logic [PTR_W-1:0]   rd;
        logic [PTR_W-1:0]   wr;
        logic [CNT_W-1:0]   cnt;
    } qstate_t;

    qstate_t s_d, s_q;
    logic do_push, do_pop, is_full;

    function automatic logic [PTR_W-1:0] ptr_next(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    always_comb begin
        s_d     = s_q;
        is_full = (s_q.cnt == CNT_W'(DEPTH));
        do_pop  = pop && (s_q.cnt != '0);
        do_push = push && !is_full;
        if (do_push) begin
            s_d.mem[s_q.wr] = push_entry;
            s_d.wr          = ptr_next(s_q.wr);
        end
        if (do_pop) begin
            s_d.rd = ptr_next(s_q.rd);
        end
        case ({do_push, do_pop})
            2'b10:   s_d.cnt = s_q.cnt + 1'b1;
            2'b01:   s_d.cnt = s_q.cnt - 1'b1;
            default: s_d.cnt = s_q.cnt;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign head     = s_q.mem[s_q.rd];
    assign valid    = (s_q.cnt != '0);
    assign count    = CNT_FLD'(s_q.cnt);
    assign drop     = push && is_full;
    assign hit_full = do_push && !do_pop && (s_q.cnt == CNT_W'(DEPTH - 1));

    // R4
    drop_keeps_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (push && is_full && !pop) |=> (s_q.cnt == $past(s_q.cnt)));
    // R2
    push_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (push && !is_full && !pop) |=> (s_q.cnt == $past(s_q.cnt) + 1'b1));
    // R10
    pop_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pop && !push && s_q.cnt == '0) |=> (s_q.cnt == '0));
    // R2
    count_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.cnt <= CNT_W'(DEPTH));
endmodule

// File: rtl/cmdmbx_irq.sv
module cmdmbx_irq (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [2:0] set_vec,
    input  logic       clr_we,
    input  logic [2:0] clr_bits,
    input  logic       mask_we,
    input  logic [2:0] mask_bits,
    output logic [2:0] stat,
    output logic [2:0] mask,
    output logic       irq
);
    typedef struct packed {
        logic [2:0] stat;
        logic [2:0] mask;
    } istate_t;

    istate_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (clr_we)  s_d.stat = s_q.stat & ~clr_bits;
        s_d.stat = s_d.stat | set_vec;
        if (mask_we) s_d.mask = mask_bits;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q.stat <= '0;
            s_q.mask <= '1;
        end else begin
            s_q <= s_d;
        end
    end

    assign stat = s_q.stat;
    assign mask = s_q.mask;
    assign irq  = |(s_q.stat & ~s_q.mask);

    // R7
    set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        set_vec[0] |=> stat[0]);
    // R5
    full_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
        set_vec[2] |=> stat[2]);
    // R8
    full_mask_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mask_we && mask_bits == 3'b111) |=> !irq);
endmodule

// File: rtl/cmdmbx_result.sv
module cmdmbx_result
    import cmdmbx_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  logic   done,
    input  word_t  retval_in,
    input  block_t words_in,
    output word_t  retval,
    output block_t words
);
    typedef struct packed {
        word_t  ret;
        block_t res;
    } rstate_t;

    rstate_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (done) begin
            s_d.ret = retval_in;
            s_d.res = words_in;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign retval = s_q.ret;
    assign words  = s_q.res;

    // R6
    ret_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> (retval == $past(retval_in)));
    // R6
    hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !done |=> $stable(retval));
endmodule

// File: rtl/cmdmbx_top.sv
module cmdmbx_top
    import cmdmbx_pkg::*;
#(
    parameter int unsigned ADDR_W = 8,
    parameter int unsigned DEPTH  = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic          bus_we,
    input  logic [31:0]   bus_wdata,
    output logic [31:0]   bus_rdata,
    output logic          irq,
    input  logic          cp_ready,
    output logic          cp_valid,
    output logic [31:0]   cp_cmd,
    output logic [511:0]  cp_params,
    input  logic          cp_pop,
    input  logic          cp_done,
    input  logic [31:0]   cp_retval,
    input  logic [511:0]  cp_status
);
    localparam int unsigned WIX_W = ADDR_W - 2;

    typedef struct packed {
        block_t prm;
    } pstate_t;

    pstate_t s_d, s_q;

    logic [WIX_W-1:0] wix;
    logic             aligned, wr_ok;
    logic             push, drop, hit_full;
    entry_t           push_entry, head;
    logic [CNT_FLD-1:0] count;
    logic [2:0]       istat, imask, set_vec, sel_bits;
    word_t            ret_word;
    block_t           res_words;

    assign wix     = bus_addr[ADDR_W-1:2];
    assign aligned = (bus_addr[1:0] == 2'b00);
    assign wr_ok   = bus_we && aligned;
    assign push    = wr_ok && (int'(wix) == WIX_CMD);

    assign push_entry.cmd = bus_wdata;
    assign push_entry.prm = s_q.prm;

    assign sel_bits = {bus_wdata[BIT_FULL], bus_wdata[BIT_OVF], bus_wdata[BIT_DONE]};
    assign set_vec  = {hit_full, drop, cp_done};

    always_comb begin
        s_d = s_q;
        if (wr_ok && int'(wix) < N_WORDS) begin
            s_d.prm[int'(wix)*WORD_W +: WORD_W] = bus_wdata;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    cmdmbx_queue #(.DEPTH(DEPTH)) u_queue (
        .clk        (clk),
        .rst_n      (rst_n),
        .push       (push),
        .push_entry (push_entry),
        .pop        (cp_pop),
        .head       (head),
        .valid      (cp_valid),
        .count      (count),
        .drop       (drop),
        .hit_full   (hit_full)
    );

    cmdmbx_irq u_irq (
        .clk       (clk),
        .rst_n     (rst_n),
        .set_vec   (set_vec),
        .clr_we    (wr_ok && int'(wix) == WIX_ISTAT),
        .clr_bits  (sel_bits),
        .mask_we   (wr_ok && int'(wix) == WIX_IMASK),
        .mask_bits (sel_bits),
        .stat      (istat),
        .mask      (imask),
        .irq       (irq)
    );

    cmdmbx_result u_result (
        .clk       (clk),
        .rst_n     (rst_n),
        .done      (cp_done),
        .retval_in (cp_retval),
        .words_in  (cp_status),
        .retval    (ret_word),
        .words     (res_words)
    );

    assign cp_cmd    = head.cmd;
    assign cp_params = head.prm;

    always_comb begin
        bus_rdata = '0;
        if (int'(wix) < N_WORDS) begin
            bus_rdata = s_q.prm[int'(wix)*WORD_W +: WORD_W];
        end else if (int'(wix) == WIX_RET) begin
            bus_rdata = ret_word;
        end else if (int'(wix) >= WIX_RES0 && int'(wix) < WIX_RES0 + N_WORDS) begin
            bus_rdata = res_words[(int'(wix) - WIX_RES0)*WORD_W +: WORD_W];
        end else if (int'(wix) == WIX_QSTAT) begin
            bus_rdata[CNT_FLD-1:0] = count;
            bus_rdata[BIT_RDY]     = cp_ready;
        end else if (int'(wix) == WIX_ISTAT) begin
            bus_rdata[BIT_DONE] = istat[0];
            bus_rdata[BIT_OVF]  = istat[1];
            bus_rdata[BIT_FULL] = istat[2];
        end else if (int'(wix) == WIX_IMASK) begin
            bus_rdata[BIT_DONE] = imask[0];
            bus_rdata[BIT_OVF]  = imask[1];
            bus_rdata[BIT_FULL] = imask[2];
        end
    end

    // R6
    done_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cp_done |=> istat[0]);
    // R4
    drop_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (push && count == CNT_FLD'(DEPTH)) |=> istat[1]);
    // R2
    head_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cp_valid && !cp_pop) |=> $stable(cp_cmd));
endmodule

// File: tb/tb_cmdmbx_top.sv
`timescale 1ns/1ps
module tb_cmdmbx_top;
    logic         clk = 1'b0;
    logic         rst_n;
    logic [7:0]   bus_addr;
    logic         bus_we;
    logic [31:0]  bus_wdata;
    logic [31:0]  bus_rdata;
    logic         irq;
    logic         cp_ready;
    logic         cp_valid;
    logic [31:0]  cp_cmd;
    logic [511:0] cp_params;
    logic         cp_pop;
    logic         cp_done;
    logic [31:0]  cp_retval;
    logic [511:0] cp_status;

    int checks = 0;
    int errors = 0;
    bit finished = 0;
    logic [31:0] prm_exp [16];
    logic [31:0] rv;

    always #2.5 clk = ~clk;

    cmdmbx_top dut (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq),
        .cp_ready(cp_ready), .cp_valid(cp_valid), .cp_cmd(cp_cmd),
        .cp_params(cp_params), .cp_pop(cp_pop), .cp_done(cp_done),
        .cp_retval(cp_retval), .cp_status(cp_status)
    );

    // {addr, data} for argument words 0..7
    localparam logic [39:0] VEC [8] = '{
        {8'h00, 32'hFFFF_FFFF},
        {8'h04, 32'h0000_0000},
        {8'h08, 32'hA5A5_A5A5},
        {8'h0C, 32'h5A5A_5A5A},
        {8'h10, 32'h0000_0001},
        {8'h14, 32'h8000_0000},
        {8'h18, 32'h1234_5678},
        {8'h1C, 32'hCAFE_F00D}
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_we = 1'b1; bus_wdata = d;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    task automatic pop1();
        @(negedge clk);
        cp_pop = 1'b1;
        @(negedge clk);
        cp_pop = 1'b0;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            errors++;
            $display("FAIL R9 watchdog actual=hung expected=done");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; bus_addr = '0; bus_we = 1'b0; bus_wdata = '0;
        cp_ready = 1'b0; cp_pop = 1'b0; cp_done = 1'b0;
        cp_retval = '0; cp_status = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R9 reset state
        rd(8'hC4, rv); chk("R9 qstat", rv, 32'h0);
        rd(8'hC8, rv); chk("R9 istat", rv, 32'h0);
        rd(8'h80, rv); chk("R9 retval", rv, 32'h0);
        chk("R9 valid", {31'b0, cp_valid}, 32'h0);
        chk("R9 irq", {31'b0, irq}, 32'h0);
        rd(8'hCC, rv); chk("R8 mask reset", rv, 32'h0006_0001);
        rd(8'h3C, rv); chk("R1 param reset", rv, 32'h0);

        // R1 table walk plus computed upper words
        for (int i = 0; i < 8; i++) begin
            wr(VEC[i][39:32], VEC[i][31:0]);
            prm_exp[i] = VEC[i][31:0];
        end
        for (int i = 8; i < 16; i++) begin
            prm_exp[i] = 32'h0101_0101 * i;
            wr(8'(4 * i), prm_exp[i]);
        end
        wr(8'h05, 32'h7777_7777); // unaligned: ignored
        for (int i = 0; i < 16; i++) begin
            rd(8'(4 * i), rv); chk("R1 param readback", rv, prm_exp[i]);
        end

        // R2 enqueue and snapshot
        wr(8'h40, 32'h0000_00A1);
        rd(8'hC4, rv); chk("R3 count one", rv, 32'h1);
        chk("R2 valid", {31'b0, cp_valid}, 32'h1);
        chk("R2 head cmd", cp_cmd, 32'hA1);
        for (int i = 0; i < 16; i++)
            chk("R2 head param", cp_params[32*i +: 32], prm_exp[i]);
        rd(8'h40, rv); chk("R2 cmd reads zero", rv, 32'h0);
        wr(8'h00, 32'hDEAD_0000);
        chk("R2 snapshot kept", cp_params[31:0], prm_exp[0]);
        wr(8'h40, 32'h0000_00A2);
        wr(8'h40, 32'h0000_00A3);
        rd(8'hC8, rv); chk("R5 not yet full", rv, 32'h0);
        wr(8'h40, 32'h0000_00A4);
        rd(8'hC4, rv); chk("R3 count four", rv, 32'h4);
        rd(8'hC8, rv); chk("R5 full flag", rv, 32'h0004_0000);
        wr(8'h40, 32'h0000_00A5);
        rd(8'hC4, rv); chk("R4 count unchanged", rv, 32'h4);
        rd(8'hC8, rv); chk("R4 overflow flag", rv, 32'h0006_0000);
        chk("R4 head unchanged", cp_cmd, 32'hA1);
        cp_ready = 1'b1;
        rd(8'hC4, rv); chk("R3 ready bit", rv, 32'h104);

        // R8 mask and R7 clear
        chk("R8 masked quiet", {31'b0, irq}, 32'h0);
        wr(8'hCC, 32'h0);
        rd(8'hCC, rv); chk("R8 mask readback", rv, 32'h0);
        chk("R8 irq raised", {31'b0, irq}, 32'h1);
        wr(8'hC8, 32'h0);
        rd(8'hC8, rv); chk("R7 write zero keeps", rv, 32'h0006_0000);
        wr(8'hC8, 32'h0004_0000);
        rd(8'hC8, rv); chk("R7 clear full", rv, 32'h0002_0000);
        chk("R8 irq held", {31'b0, irq}, 32'h1);
        wr(8'hC8, 32'h0002_0000);
        rd(8'hC8, rv); chk("R7 clear ovf", rv, 32'h0);
        chk("R8 irq low", {31'b0, irq}, 32'h0);

        // R2 pop order
        pop1();
        chk("R2 pop head", cp_cmd, 32'hA2);
        chk("R2 second snapshot", cp_params[31:0], 32'hDEAD_0000);
        rd(8'hC4, rv); chk("R2 count after pop", rv, 32'h103);

        // R10 simultaneous push and pop
        @(negedge clk);
        bus_addr = 8'h40; bus_we = 1'b1; bus_wdata = 32'hB5; cp_pop = 1'b1;
        @(negedge clk);
        bus_we = 1'b0; cp_pop = 1'b0;
        rd(8'hC4, rv); chk("R10 push pop count", rv, 32'h103);
        chk("R10 push pop head", cp_cmd, 32'hA3);
        rd(8'hC8, rv); chk("R5 no full on push pop", rv, 32'h0);
        pop1(); chk("R2 order A4", cp_cmd, 32'hA4);
        pop1(); chk("R2 order B5", cp_cmd, 32'hB5);
        pop1();
        chk("R2 empty valid", {31'b0, cp_valid}, 32'h0);
        pop1();
        rd(8'hC4, rv); chk("R10 pop empty", rv, 32'h100);

        // R6 results
        cp_retval = 32'h0000_0055;
        for (int i = 0; i < 16; i++) cp_status[32*i +: 32] = 32'h5000_0000 + 32'h0101 * i;
        @(negedge clk); cp_done = 1'b1;
        @(negedge clk); cp_done = 1'b0;
        cp_retval = 32'hFFFF_FFFF; cp_status = '1;
        rd(8'h80, rv); chk("R6 retval", rv, 32'h55);
        for (int i = 0; i < 16; i++) begin
            rd(8'(8'h84 + 4 * i), rv); chk("R6 result word", rv, 32'h5000_0000 + 32'h0101 * i);
        end
        rd(8'hC8, rv); chk("R6 done flag", rv, 32'h1);
        chk("R8 irq on done", {31'b0, irq}, 32'h1);

        // R7 set wins over clear
        @(negedge clk);
        bus_addr = 8'hC8; bus_we = 1'b1; bus_wdata = 32'h1; cp_done = 1'b1;
        @(negedge clk);
        bus_we = 1'b0; cp_done = 1'b0;
        rd(8'hC8, rv); chk("R7 set wins", rv, 32'h1);
        wr(8'hCC, 32'h0000_0001);
        chk("R8 mask done", {31'b0, irq}, 32'h0);
        wr(8'hC8, 32'hFFFF_FFFF);
        rd(8'hC8, rv); chk("R7 clear all", rv, 32'h0);

        finished = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule